// File: doc/BRIEF.md
# Two-Color Cursor Overlay

This block places a 32x32 cursor with two colors over the pixel stream of a raster display. A host writes the cursor image and its position through a small word-addressed write port. The image is two planes of 32 row words. The first plane says where the cursor is opaque. The second plane picks one of two cursor colors at each opaque pixel. The position is one packed word that holds a signed x and a signed y.

The video timing logic supplies the current beam coordinates and a pixel-valid strobe. For each valid pixel, the block reports one cycle later whether the cursor covers that pixel and which cursor color applies. Turning the color select into RGB is done by a palette stage downstream.

Host writes go into shadow copies. A frame-start pulse moves all the shadow copies into the active set in one step, so the cursor never changes in the middle of a frame. To hide the cursor, software places it at (-32, -32). There is no enable bit.

Top module: `cursor_overlay`

## Requirements
- R1: After reset the cursor-hit, color-select and output-valid outputs are 0. All shape rows are 0. The position is (-32, -32), in both the shadow and the active set.
- R2: The write address selects the target. Address 0 is the position, with x in bits 31:16 and y in bits 15:0. Row r of the opacity plane is at address 1+r. Row r of the color plane is at address 33+r. A write to any address from 65 upward changes nothing.
- R3: x and y are signed 16-bit values. The beam coordinates are unsigned. A pixel (px, py) is inside the cursor when 0 <= px-x < 32 and 0 <= py-y < 32. This includes positions where part of the cursor lies at negative coordinates.
- R4: Bit 31 of a row word is the leftmost cursor column. Column c = px-x uses bit 31-c of row py-y.
- R5: cursor_hit is 1 only for a pixel inside the cursor whose opacity bit is 1.
- R6: When cursor_hit is 1, cursor_color equals the color-plane bit of that pixel. Otherwise cursor_color is 0.
- R7: out_valid is pix_valid delayed by one clock. cursor_hit and cursor_color belong to the pixel presented one clock earlier, and both are 0 when that pixel was not valid.
- R8: Host writes have no effect on the outputs until a frame_start pulse. Pixels presented in the clock after frame_start use the shadow values as they stood at that pulse.
- R9: With the position at (-32, -32), no pixel is ever reported as covered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Host write strobe |
| reg_addr | input | 7 | Host word address |
| reg_wdata | input | 32 | Host write data |
| frame_start | input | 1 | Copies shadow state into the active set |
| pix_valid | input | 1 | Beam coordinates are a visible pixel |
| pix_x | input | 16 | Beam column, unsigned |
| pix_y | input | 16 | Beam row, unsigned |
| cursor_hit | output | 1 | Cursor covers the pixel |
| cursor_color | output | 1 | Cursor color select for the pixel |
| out_valid | output | 1 | pix_valid delayed one clock |

## Verification
Every pixel result is due exactly one clock after its coordinates are presented. The bench drives inputs on the falling edge and reads all three outputs at the next falling edge. Each sample therefore sees exactly one register stage.

A host write takes one clock to reach the shadow copy. A frame_start pulse takes one clock to reach the active set. The bench finishes each write or frame pulse before it presents the next pixel, and it probes pixels on both sides of a pulse to show that nothing takes effect early.

The cursor area and a two-pixel border around it are swept pixel by pixel at an on-screen position and at a partly negative position. The expected values come from the bench's own copy of the planes.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
  localparam int unsigned CURSOR_DIM = 32;
  localparam int unsigned COORD_BITS = 16;
  localparam int unsigned WORD_BITS  = 2 * COORD_BITS;

  typedef logic [COORD_BITS-1:0] coord_t;
  typedef logic signed [COORD_BITS+1:0] rel_t;

  typedef struct packed {
    coord_t x;
    coord_t y;
  } curpos_t;

  localparam coord_t  OFF_COORD = coord_t'(-CURSOR_DIM);
  localparam curpos_t OFF_POS   = '{x: OFF_COORD, y: OFF_COORD};

  // offset of an unsigned beam coordinate from a signed cursor origin
  function automatic rel_t rel_coord(coord_t beam, coord_t origin);
    return $signed({2'b00, beam}) - $signed({{2{origin[COORD_BITS-1]}}, origin});
  endfunction

  function automatic logic in_span(rel_t r);
    return (r >= rel_t'(0)) && (r < rel_t'(CURSOR_DIM));
  endfunction
endpackage

// File: rtl/cursor_regs.sv
module cursor_regs
  import cursor_pkg::*;
#(
  parameter int unsigned ROWS   = CURSOR_DIM,
  parameter int unsigned ADDR_W = 7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [WORD_BITS-1:0]      wr_data,
  input  logic                      frame_start,
  output curpos_t                   act_pos,
  output logic [ROWS-1:0][ROWS-1:0] act_mask,
  output logic [ROWS-1:0][ROWS-1:0] act_color
);
  localparam int unsigned MASK_BASE  = 1;
  localparam int unsigned COLOR_BASE = MASK_BASE + ROWS;

  curpos_t                   shd_pos;
  logic [ROWS-1:0][ROWS-1:0] shd_mask;
  logic [ROWS-1:0][ROWS-1:0] shd_color;
  logic [ROWS-1:0]           mask_we;
  logic [ROWS-1:0]           color_we;
  logic                      pos_we;

  assign pos_we = wr_en && (wr_addr == '0);

  for (genvar r = 0; r < ROWS; r++) begin : g_dec
    assign mask_we[r]  = wr_en && (wr_addr == ADDR_W'(MASK_BASE + r));
    assign color_we[r] = wr_en && (wr_addr == ADDR_W'(COLOR_BASE + r));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shd_pos   <= OFF_POS;
      shd_mask  <= '0;
      shd_color <= '0;
    end else begin
      if (pos_we) shd_pos <= wr_data;
      for (int r = 0; r < ROWS; r++) begin
        if (mask_we[r])  shd_mask[r]  <= wr_data[ROWS-1:0];
        if (color_we[r]) shd_color[r] <= wr_data[ROWS-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_pos   <= OFF_POS;
      act_mask  <= '0;
      act_color <= '0;
    end else if (frame_start) begin
      act_pos   <= shd_pos;
      act_mask  <= shd_mask;
      act_color <= shd_color;
    end
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(act_pos) && $stable(act_mask) && $stable(act_color)));

  assert_promote_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (act_pos == $past(shd_pos) && act_mask == $past(shd_mask)
                     && act_color == $past(shd_color)));

  assert_one_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({pos_we, mask_we, color_we}) <= 1);
endmodule

// File: rtl/cursor_hit_unit.sv
module cursor_hit_unit
  import cursor_pkg::*;
#(
  parameter int unsigned DIM = CURSOR_DIM
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pix_valid,
  input  coord_t                  pix_x,
  input  coord_t                  pix_y,
  input  curpos_t                 pos,
  input  logic [DIM-1:0][DIM-1:0] mask,
  input  logic [DIM-1:0][DIM-1:0] color,
  output logic                    cursor_hit,
  output logic                    cursor_color,
  output logic                    out_valid
);
  localparam int unsigned IDX_W = $clog2(DIM);

  rel_t             rel_x, rel_y;
  logic             in_window;
  logic [IDX_W-1:0] col_idx, row_idx, bit_sel;
  logic             mask_bit, color_bit;

  always_comb begin
    rel_x     = rel_coord(pix_x, pos.x);
    rel_y     = rel_coord(pix_y, pos.y);
    in_window = in_span(rel_x) && in_span(rel_y);
    col_idx   = rel_x[IDX_W-1:0];
    row_idx   = rel_y[IDX_W-1:0];
    bit_sel   = IDX_W'(DIM - 1) - col_idx;
    mask_bit  = mask[row_idx][bit_sel];
    color_bit = color[row_idx][bit_sel];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      cursor_hit   <= 1'b0;
      cursor_color <= 1'b0;
    end else begin
      out_valid    <= pix_valid;
      cursor_hit   <= pix_valid && in_window && mask_bit;
      cursor_color <= pix_valid && in_window && mask_bit && color_bit;
    end
  end

  assert_valid_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> out_valid);

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> (!out_valid && !cursor_hit && !cursor_color));

  assert_color_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cursor_color |-> cursor_hit);

  assert_mask_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !(in_window && mask_bit)) |=> !cursor_hit);

  assert_offscreen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pos == OFF_POS) |=> !cursor_hit);
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import cursor_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [6:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  input  logic        frame_start,
  input  logic        pix_valid,
  input  logic [15:0] pix_x,
  input  logic [15:0] pix_y,
  output logic        cursor_hit,
  output logic        cursor_color,
  output logic        out_valid
);
  localparam int unsigned DIM    = CURSOR_DIM;
  localparam int unsigned ADDR_W = $clog2(2 * DIM + 1);

  curpos_t                 act_pos;
  logic [DIM-1:0][DIM-1:0] act_mask;
  logic [DIM-1:0][DIM-1:0] act_color;

  cursor_regs #(.ROWS(DIM), .ADDR_W(ADDR_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (reg_we),
    .wr_addr     (reg_addr),
    .wr_data     (reg_wdata),
    .frame_start (frame_start),
    .act_pos     (act_pos),
    .act_mask    (act_mask),
    .act_color   (act_color)
  );

  cursor_hit_unit #(.DIM(DIM)) u_hit (
    .clk          (clk),
    .rst_n        (rst_n),
    .pix_valid    (pix_valid),
    .pix_x        (pix_x),
    .pix_y        (pix_y),
    .pos          (act_pos),
    .mask         (act_mask),
    .color        (act_color),
    .cursor_hit   (cursor_hit),
    .cursor_color (cursor_color),
    .out_valid    (out_valid)
  );
endmodule

// File: tb/cursor_overlay_bench.sv
`timescale 1ns/1ps
module cursor_overlay_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [6:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic        frame_start;
  logic        pix_valid;
  logic [15:0] pix_x, pix_y;
  logic        cursor_hit, cursor_color, out_valid;

  always #2.5 clk = ~clk;

  cursor_overlay u_cursor_overlay (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .frame_start(frame_start), .pix_valid(pix_valid),
    .pix_x(pix_x), .pix_y(pix_y), .cursor_hit(cursor_hit),
    .cursor_color(cursor_color), .out_valid(out_valid)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] sm [32];
  logic [31:0] sc [32];
  logic [31:0] am [32];
  logic [31:0] ac [32];
  logic [15:0] sx, sy, ax, ay;

  task automatic chk(string tag, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic host_write(int addr, logic [31:0] data);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 7'(addr); reg_wdata = data;
    @(negedge clk);
    reg_we = 1'b0;
    if (addr == 0) begin sx = data[31:16]; sy = data[15:0]; end
    else if (addr >= 1 && addr <= 32) sm[addr-1] = data;
    else if (addr >= 33 && addr <= 64) sc[addr-33] = data;
  endtask

  task automatic new_frame();
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    ax = sx; ay = sy;
    for (int r = 0; r < 32; r++) begin am[r] = sm[r]; ac[r] = sc[r]; end
  endtask

  // present one pixel, check the registered result one clock later
  task automatic probe(int px, int py, logic v, string tag);
    int dx, dy;
    logic eh, ec;
    @(negedge clk);
    pix_valid = v; pix_x = 16'(px); pix_y = 16'(py);
    dx = px - int'($signed(ax));
    dy = py - int'($signed(ay));
    eh = 1'b0; ec = 1'b0;
    if (v && dx >= 0 && dx < 32 && dy >= 0 && dy < 32) begin
      eh = am[dy][31-dx];
      ec = eh & ac[dy][31-dx];
    end
    @(negedge clk);
    chk(tag, "out_valid", out_valid, v);
    chk(tag, $sformatf("hit(%0d,%0d)", px, py), cursor_hit, eh);
    chk(tag, $sformatf("color(%0d,%0d)", px, py), cursor_color, ec);
    pix_valid = 1'b0;
  endtask

  task automatic sweep(int x0, int x1, int y0, int y1, string tag);
    for (int py = y0; py <= y1; py++)
      for (int px = x0; px <= x1; px++)
        probe(px, py, 1'b1, tag);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R7 watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    frame_start = 1'b0; pix_valid = 1'b0; pix_x = '0; pix_y = '0;
    sx = 16'hFFE0; sy = 16'hFFE0; ax = sx; ay = sy;
    for (int r = 0; r < 32; r++) begin sm[r] = '0; sc[r] = '0; am[r] = '0; ac[r] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: outputs idle after reset
    chk("R1", "hit", cursor_hit, 1'b0);
    chk("R1", "color", cursor_color, 1'b0);
    chk("R1", "out_valid", out_valid, 1'b0);
    new_frame();
    // R1 / R9: reset position is off-screen
    sweep(0, 3, 0, 3, "R1");

    for (int r = 0; r < 32; r++) begin
      host_write(1 + r, 32'hC3A5_96F0 ^ (32'(r) * 32'h0101_0101));
      host_write(33 + r, 32'h5A5A_F00F ^ (32'(r) * 32'h0011_2233));
    end
    host_write(0, {16'd10, 16'd20});
    // R8: not yet promoted
    probe(10, 20, 1'b1, "R8");
    probe(12, 21, 1'b1, "R8");
    new_frame();
    // R3 R4 R5 R6: full window plus border
    sweep(8, 43, 18, 53, "R3/R4/R5/R6");
    // R7: invalid pixel inside the cursor
    probe(10, 20, 1'b0, "R7");
    probe(11, 20, 1'b0, "R7");

    // R2: out-of-map addresses are ignored
    host_write(65, 32'h0000_0000);
    host_write(100, 32'hFFFF_FFFF);
    host_write(127, 32'h0000_0000);
    new_frame();
    sweep(9, 42, 20, 21, "R2");

    // R8: shadow change invisible until the next frame
    host_write(1, 32'h0000_0000);
    host_write(0, {16'hFFFB, 16'hFFFD});
    sweep(8, 14, 20, 20, "R8");
    new_frame();
    // R3: partly negative position
    sweep(0, 30, 0, 32, "R3");

    // R9: hide at (-32, -32)
    host_write(0, 32'hFFE0_FFE0);
    new_frame();
    sweep(0, 35, 0, 35, "R9");
    finish_run();
  end
endmodule